// File: doc/BRIEF.md
# Retention-Aware Row Refresh Scheduler

This block chooses which DRAM rows receive a refresh and in which time window. Rows with weak retention are recorded in one of two compact hashed bit-array filters. One filter marks rows that need refresh in every 64 ms window. The other marks rows that need refresh every 128 ms. Every other row is refreshed once per 256 ms. A profiling agent loads the filters through an insert port, and can do so before traffic starts or while the scheduler runs. A clear strobe empties both filters.

A scaled timebase divides time into windows of `WINDOW_CYCLES` clock cycles, numbered 0 to 3 in a repeating cycle. At the start of each window the block walks every row address in ascending order. For each row it tests both filters and then either raises a refresh request or skips the row. Requests leave on a valid/ready handshake that carries the row address. While a request waits for ready, the walk stalls. If a window ends before the walk is finished, the block raises an overrun pulse and restarts the walk for the new window.

A filter can wrongly report a row as present, which only makes that row refresh more often. It can never fail to report a row that was inserted, so no row is refreshed less often than its bin demands.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is held, `refReqValid` is 0, `windowIdx` is 0 and `overrun` is 0.
- R2: Each filter is a bit array of `FILTER_BITS` bits (a power of two) with `HASHES` index functions. Function j rotates the row address left by (j mod `ROW_BITS`) positions within `ROW_BITS` bits. It then zero-pads the result to a whole number of `log2(FILTER_BITS)`-bit chunks and XORs all the chunks together. An insert sets every indexed bit. A test passes only when every indexed bit is set.
- R3: A row that passes the fast-filter test (`profFast`=1 at insert) is requested in every window.
- R4: A row that passes only the medium-filter test (`profFast`=0 at insert) is requested in windows 0 and 2 only.
- R5: A row that passes neither test is requested in window 0 only.
- R6: A row that passes both tests is refreshed at the fast rate, in every window.
- R7: Within one window each row is requested at most once, and rows are requested in strictly ascending address order.
- R8: Once `refReqValid` is 1 it stays 1, with `refReqRow` unchanged, until a cycle in which `refReqReady` is 1, unless the window ends first. No later row is requested while a request waits.
- R9: Every window lasts exactly `WINDOW_CYCLES` cycles. At the end of a window, `windowIdx` advances by one modulo 4.
- R10: If the walk has not finished when a window ends, `overrun` is 1 for exactly the first cycle of the next window. Any pending request is dropped, and the walk restarts at row 0. In all other cycles `overrun` is 0.
- R11: `profClear` empties both filters. If it is asserted in the same cycle as an insert, the clear wins and the insert has no effect.
- R12: An insert takes effect at the next clock edge, so rows that the walk tests after that edge see the new membership within the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| profValid | input | 1 | Insert strobe for one row into a filter |
| profFast | input | 1 | Filter select for the insert: 1 selects the fast (64 ms) bin, 0 selects the medium (128 ms) bin |
| profRow | input | ROW_BITS | Row address to insert |
| profClear | input | 1 | Clears both filters |
| refReqValid | output | 1 | A refresh request is present |
| refReqRow | output | ROW_BITS | Row address of the refresh request |
| refReqReady | input | 1 | The consumer accepts the request in this cycle |
| windowIdx | output | 2 | Index (0 to 3) of the current window |
| overrun | output | 1 | One-cycle pulse: the previous window ended before its walk was finished |

## Verification
On every cycle the assertions check four things. A waiting request holds its row until it is accepted or the window ends. The window index only steps forward by one. An overrun pulse appears only when the window changes, and never together with a live request. Within a window, each newly raised request carries a higher row than the last accepted one. Which rows are requested in which window can only be shown by the bench scenarios, because that depends on the filter contents. The bench covers fast-bin, medium-bin, both-bin and default rows, the effect of a clear that collides with an insert, an insert that lands in the middle of a window, and the restart after a forced overrun.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // number of hashed filters (fast bin, medium bin)
  localparam int NumFilters = 2;
  // windows per slowest refresh period (64 ms windows in a 256 ms period)
  localparam int NumWindows = 4;

  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rowRestart;
    logic rowStep;
    logic reqLoad;
  } rfshStrobe_t;

endpackage

// File: rtl/rfsh_bloom.sv
module rfsh_bloom #(
  parameter int ROW_BITS    = 6,
  parameter int FILTER_BITS = 32,
  parameter int HASHES      = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearAll,
  input  logic                insEn,
  input  logic [ROW_BITS-1:0] insRow,
  input  logic [ROW_BITS-1:0] qRow,
  output logic                hit
);

  localparam int IdxW   = $clog2(FILTER_BITS);
  localparam int NChunk = (ROW_BITS + IdxW - 1) / IdxW;
  localparam int PadW   = NChunk * IdxW;

  logic [FILTER_BITS-1:0] bitArr;
  logic [HASHES-1:0]      qBit;

  // rotate left by (j mod ROW_BITS), then XOR-fold into IdxW bits
  function automatic logic [IdxW-1:0] hashIdx(input logic [ROW_BITS-1:0] r, input int j);
    logic [ROW_BITS-1:0] rot;
    logic [PadW-1:0]     pad;
    logic [IdxW-1:0]     acc;
    for (int b = 0; b < ROW_BITS; b++) begin
      rot[b] = r[(b + ROW_BITS - (j % ROW_BITS)) % ROW_BITS];
    end
    pad = '0;
    pad[ROW_BITS-1:0] = rot;
    acc = '0;
    for (int c = 0; c < NChunk; c++) begin
      acc = acc ^ pad[c*IdxW +: IdxW];
    end
    return acc;
  endfunction

  generate
    for (genvar j = 0; j < HASHES; j++) begin : g_probe
      assign qBit[j] = bitArr[hashIdx(qRow, j)];
    end
  endgenerate

  assign hit = &qBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitArr <= '0;
    end else if (clearAll) begin
      bitArr <= '0;
    end else if (insEn) begin
      for (int j = 0; j < HASHES; j++) begin
        bitArr[hashIdx(insRow, j)] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int ROW_BITS      = 6,
  parameter int FILTER_BITS   = 32,
  parameter int HASHES        = 2,
  parameter int WINDOW_CYCLES = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  rfshStrobe_t         strobe,
  input  logic                profValid,
  input  logic                profFast,
  input  logic [ROW_BITS-1:0] profRow,
  input  logic                profClear,
  output logic                hitFast,
  output logic                hitMid,
  output logic                lastRow,
  output logic                windowEnd,
  output logic [1:0]          winIdx,
  output logic [ROW_BITS-1:0] refReqRow
);

  localparam int TickW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [TickW-1:0] TickLast = TickW'(WINDOW_CYCLES - 1);

  logic [TickW-1:0]      tickCnt;
  logic [ROW_BITS-1:0]   rowPtr;
  logic [NumFilters-1:0] binHit;

  // filter 0 = fast bin, filter 1 = medium bin
  generate
    for (genvar f = 0; f < NumFilters; f++) begin : g_bin
      logic selIns;
      assign selIns = profValid & (profFast == (f == 0));
      rfsh_bloom #(
        .ROW_BITS   (ROW_BITS),
        .FILTER_BITS(FILTER_BITS),
        .HASHES     (HASHES)
      ) u_bloom (
        .clk     (clk),
        .rstN    (rstN),
        .clearAll(profClear),
        .insEn   (selIns),
        .insRow  (profRow),
        .qRow    (rowPtr),
        .hit     (binHit[f])
      );
    end
  endgenerate

  assign hitFast   = binHit[0];
  assign hitMid    = binHit[1];
  assign lastRow   = (rowPtr == {ROW_BITS{1'b1}});
  assign windowEnd = (tickCnt == TickLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      winIdx  <= 2'd0;
    end else if (windowEnd) begin
      tickCnt <= '0;
      winIdx  <= winIdx + 2'd1;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowPtr    <= '0;
      refReqRow <= '0;
    end else begin
      if (strobe.rowRestart) begin
        rowPtr <= '0;
      end else if (strobe.rowStep) begin
        rowPtr <= rowPtr + 1'b1;
      end
      if (strobe.reqLoad) begin
        refReqRow <= rowPtr;
      end
    end
  end

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hitFast,
  input  logic        hitMid,
  input  logic        lastRow,
  input  logic        windowEnd,
  input  logic [1:0]  winIdx,
  input  logic        refReqReady,
  output rfshStrobe_t strobe,
  output logic        refReqValid,
  output logic        overrun
);

  walkState_t state, stateNext;
  logic       validNext;
  logic       needRow;

  // fast rows every window, medium rows in even windows, others in window 0
  assign needRow = hitFast | (hitMid & ~winIdx[0]) | (winIdx == 2'd0);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    validNext = refReqValid;
    if (windowEnd) begin
      strobe.rowRestart = 1'b1;
      stateNext         = ST_SCAN;
      validNext         = 1'b0;
    end else begin
      case (state)
        ST_SCAN: begin
          if (needRow) begin
            strobe.reqLoad = 1'b1;
            validNext      = 1'b1;
            stateNext      = ST_WAIT;
          end else if (lastRow) begin
            stateNext = ST_DONE;
          end else begin
            strobe.rowStep = 1'b1;
          end
        end
        ST_WAIT: begin
          if (refReqReady) begin
            validNext = 1'b0;
            if (lastRow) begin
              stateNext = ST_DONE;
            end else begin
              strobe.rowStep = 1'b1;
              stateNext      = ST_SCAN;
            end
          end
        end
        default: begin
          stateNext = ST_DONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_SCAN;
      refReqValid <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      state       <= stateNext;
      refReqValid <= validNext;
      overrun     <= windowEnd && (state != ST_DONE);
    end
  end

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int ROW_BITS      = 6,
  parameter int FILTER_BITS   = 32,
  parameter int HASHES        = 2,
  parameter int WINDOW_CYCLES = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                profValid,
  input  logic                profFast,
  input  logic [ROW_BITS-1:0] profRow,
  input  logic                profClear,
  output logic                refReqValid,
  output logic [ROW_BITS-1:0] refReqRow,
  input  logic                refReqReady,
  output logic [1:0]          windowIdx,
  output logic                overrun
);

  rfshStrobe_t strobe;
  logic        hitFast;
  logic        hitMid;
  logic        lastRow;
  logic        windowEnd;

  rfsh_datapath #(
    .ROW_BITS     (ROW_BITS),
    .FILTER_BITS  (FILTER_BITS),
    .HASHES       (HASHES),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .profValid(profValid),
    .profFast (profFast),
    .profRow  (profRow),
    .profClear(profClear),
    .hitFast  (hitFast),
    .hitMid   (hitMid),
    .lastRow  (lastRow),
    .windowEnd(windowEnd),
    .winIdx   (windowIdx),
    .refReqRow(refReqRow)
  );

  rfsh_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hitFast    (hitFast),
    .hitMid     (hitMid),
    .lastRow    (lastRow),
    .windowEnd  (windowEnd),
    .winIdx     (windowIdx),
    .refReqReady(refReqReady),
    .strobe     (strobe),
    .refReqValid(refReqValid),
    .overrun    (overrun)
  );

endmodule

// File: rtl/rfsh_sched_checker.sv
module rfsh_sched_checker #(
  parameter int ROW_BITS = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                refReqValid,
  input logic                refReqReady,
  input logic [ROW_BITS-1:0] refReqRow,
  input logic [1:0]          windowIdx,
  input logic                overrun,
  input logic                windowEnd
);

  logic                haveAcc;
  logic [ROW_BITS-1:0] lastAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveAcc <= 1'b0;
      lastAcc <= '0;
    end else if (windowEnd) begin
      haveAcc <= 1'b0;
    end else if (refReqValid && refReqReady) begin
      haveAcc <= 1'b1;
      lastAcc <= refReqRow;
    end
  end

  // R8: a waiting request holds until accepted or the window ends
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refReqValid && !refReqReady && !windowEnd) |=> (refReqValid && $stable(refReqRow)));

  // R9: window index only steps forward by one
  assert_window_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(windowIdx) |-> (windowIdx == $past(windowIdx) + 2'd1));

  // R10: overrun pulse only at a window change, with the pending request dropped
  assert_overrun_at_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> (!$stable(windowIdx) && !refReqValid));

  // R7: rows rise strictly within a window
  assert_ascending_rows_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(refReqValid) && haveAcc) |-> (refReqRow > lastAcc));

endmodule

bind rfsh_sched rfsh_sched_checker #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refReqValid(refReqValid),
  .refReqReady(refReqReady),
  .refReqRow  (refReqRow),
  .windowIdx  (windowIdx),
  .overrun    (overrun),
  .windowEnd  (windowEnd)
);

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;

  localparam int RB    = 6;
  localparam int FB    = 32;
  localparam int HK    = 2;
  localparam int WC    = 256;
  localparam int NROWS = 1 << RB;
  localparam int IDXW  = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          profValid = 1'b0;
  logic          profFast = 1'b0;
  logic [RB-1:0] profRow = '0;
  logic          profClear = 1'b0;
  logic          refReqValid;
  logic [RB-1:0] refReqRow;
  logic          refReqReady = 1'b0;
  logic [1:0]    windowIdx;
  logic          overrun;

  int errors = 0;
  int checks = 0;
  int readyMode = 0;
  int readyCnt = 0;
  bit finished = 1'b0;

  bit modA [FB];
  bit modB [FB];
  bit insA [NROWS];
  bit insB [NROWS];
  bit got  [NROWS];
  int lastOverrun = 0;
  int firstRow = -1;

  always #2 clk = ~clk;

  rfsh_sched #(.ROW_BITS(RB), .FILTER_BITS(FB), .HASHES(HK), .WINDOW_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .profValid(profValid), .profFast(profFast),
    .profRow(profRow), .profClear(profClear), .refReqValid(refReqValid),
    .refReqRow(refReqRow), .refReqReady(refReqReady), .windowIdx(windowIdx),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench hash: shift-based rotation and fold, following R2
  function automatic int hIdx(input int r, input int j);
    int s = j % RB;
    int mask = NROWS - 1;
    int v = (s == 0) ? r : (((r << s) | (r >> (RB - s))) & mask);
    int acc = 0;
    while (v != 0) begin
      acc = acc ^ (v & (FB - 1));
      v = v >> IDXW;
    end
    return acc;
  endfunction

  function automatic bit inFilt(input bit fast, input int r);
    bit res = 1'b1;
    for (int j = 0; j < HK; j++) begin
      res = res & (fast ? modA[hIdx(r, j)] : modB[hIdx(r, j)]);
    end
    return res;
  endfunction

  function automatic bit expReq(input int r, input int w);
    return inFilt(1'b1, r) || (inFilt(1'b0, r) && (w % 2 == 0)) || (w == 0);
  endfunction

  task automatic modelIns(input int r, input bit fast);
    for (int j = 0; j < HK; j++) begin
      if (fast) modA[hIdx(r, j)] = 1'b1;
      else      modB[hIdx(r, j)] = 1'b1;
    end
    if (fast) insA[r] = 1'b1;
    else      insB[r] = 1'b1;
  endtask

  task automatic insertRow(input int r, input bit fast);
    profValid = 1'b1;
    profFast  = fast;
    profRow   = RB'(r);
    modelIns(r, fast);
    @(negedge clk);
    profValid = 1'b0;
  endtask

  // ready driver, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    readyCnt++;
    case (readyMode)
      0:       refReqReady = 1'b1;
      1:       refReqReady = (readyCnt % 3 != 0);
      default: refReqReady = 1'b0;
    endcase
  end

  // R8 monitor: a waiting request must hold its row
  bit pvValid = 1'b0;
  bit pvReady = 1'b0;
  logic [RB-1:0] pvRow = '0;
  logic [1:0] pvWin = 2'd0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (pvValid && !pvReady && windowIdx == pvWin) begin
        check(refReqValid === 1'b1 && refReqRow === pvRow, "R8",
              int'(refReqRow), int'(pvRow), "held request");
      end
      pvValid = refReqValid;
      pvReady = refReqReady;
      pvRow   = refReqRow;
      pvWin   = windowIdx;
    end
  end

  // called at the first falling edge of a window; returns at the first falling edge of the next
  task automatic runWindow(input bit checkRows, input int midIns, input bit doClear, input int prevW);
    int w = int'(windowIdx);
    int cycles = 0;
    int prev = -1;
    int orderBad = 0;
    bit row0Exp;
    lastOverrun = int'(overrun);
    firstRow = -1;
    check(w == (prevW + 1) % 4, "R9", w, (prevW + 1) % 4, "window index step");
    for (int r = 0; r < NROWS; r++) got[r] = 1'b0;
    row0Exp = expReq(0, w);
    if (doClear) begin
      profClear = 1'b1;
      profValid = 1'b1;
      profFast  = 1'b1;
      profRow   = RB'(9);
      for (int i = 0; i < FB; i++) begin
        modA[i] = 1'b0;
        modB[i] = 1'b0;
      end
      for (int r = 0; r < NROWS; r++) begin
        insA[r] = 1'b0;
        insB[r] = 1'b0;
      end
    end else if (midIns >= 0) begin
      profValid = 1'b1;
      profFast  = 1'b1;
      profRow   = RB'(midIns);
      modelIns(midIns, 1'b1);
    end
    while (int'(windowIdx) == w) begin
      if (refReqValid && refReqReady) begin
        if (got[refReqRow]) orderBad++;
        if (int'(refReqRow) <= prev) orderBad++;
        if (firstRow < 0) firstRow = int'(refReqRow);
        prev = int'(refReqRow);
        got[refReqRow] = 1'b1;
      end
      @(negedge clk);
      cycles++;
      profValid = 1'b0;
      profClear = 1'b0;
    end
    check(cycles == WC, "R9", cycles, WC, "window length");
    check(orderBad == 0, "R7", orderBad, 0, "order/duplicate violations");
    if (checkRows) begin
      for (int r = 0; r < NROWS; r++) begin
        bit e = (r == 0) ? row0Exp : expReq(r, w);
        string tag;
        if (inFilt(1'b1, r) && inFilt(1'b0, r)) tag = "R6";
        else if (inFilt(1'b1, r)) tag = insA[r] ? "R3" : "R2";
        else if (inFilt(1'b0, r)) tag = insB[r] ? "R4" : "R2";
        else tag = "R5";
        check(got[r] == e, tag, int'(got[r]), int'(e), $sformatf("row %0d window %0d", r, w));
      end
    end
  endtask

  initial begin
    int w;
    for (int i = 0; i < FB; i++) begin
      modA[i] = 1'b0;
      modB[i] = 1'b0;
    end
    for (int r = 0; r < NROWS; r++) begin
      insA[r] = 1'b0;
      insB[r] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(refReqValid === 1'b0, "R1", int'(refReqValid), 0, "valid in reset");
    check(windowIdx === 2'd0, "R1", int'(windowIdx), 0, "window in reset");
    check(overrun === 1'b0, "R1", int'(overrun), 0, "overrun in reset");
    rstN = 1'b1;
    @(negedge clk);
    insertRow(3, 1'b1);
    insertRow(17, 1'b1);
    insertRow(40, 1'b1);
    insertRow(5, 1'b0);
    insertRow(17, 1'b0);
    insertRow(22, 1'b0);
    insertRow(63, 1'b0);
    w = int'(windowIdx);
    while (int'(windowIdx) == w) @(negedge clk);
    w = 0;
    // full-speed consumer
    for (int i = 0; i < 4; i++) begin
      runWindow(1'b1, -1, 1'b0, w);
      check(lastOverrun == 0, "R10", lastOverrun, 0, "no overrun at full speed");
      w = (w + 1) % 4;
    end
    // throttled consumer
    readyMode = 1;
    for (int i = 0; i < 4; i++) begin
      runWindow(1'b1, -1, 1'b0, w);
      w = (w + 1) % 4;
    end
    // stalled consumer forces an overrun
    readyMode = 2;
    runWindow(1'b0, -1, 1'b0, w);
    w = (w + 1) % 4;
    readyMode = 0;
    runWindow(1'b1, -1, 1'b0, w);
    check(lastOverrun == 1, "R10", lastOverrun, 1, "overrun after stalled window");
    begin
      int expFirst = -1;
      for (int r = NROWS - 1; r >= 0; r--) if (expReq(r, w)) expFirst = r;
      check(firstRow == expFirst, "R10", firstRow, expFirst, "restart from row 0");
    end
    w = (w + 1) % 4;
    // clear collides with an insert of row 9
    runWindow(1'b0, -1, 1'b1, w);
    w = (w + 1) % 4;
    check(lastOverrun == 0, "R10", lastOverrun, 0, "no overrun before clear window");
    while (w != 0) begin
      runWindow(1'b0, -1, 1'b0, w);
      w = (w + 1) % 4;
    end
    runWindow(1'b1, -1, 1'b0, w);
    w = (w + 1) % 4;
    runWindow(1'b1, 50, 1'b0, w);
    check(got[9] == 1'b0, "R11", int'(got[9]), 0, "row 9 insert lost to clear");
    check(got[50] == 1'b1, "R12", int'(got[50]), 1, "mid-window insert of row 50");
    w = (w + 1) % 4;
    runWindow(1'b1, -1, 1'b0, w);
    check(got[50] == 1'b1, "R12", int'(got[50]), 1, "row 50 kept in next window");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule